// File: doc/BRIEF.md
# Dual Alarm Match and Interrupt Unit

This unit holds two independent alarms. Each alarm has four byte-wide match fields: seconds, minutes, hours and day of week. On every once-per-second tick from the time-keeping logic, the unit compares each alarm against the current time. When every field of an alarm agrees, the unit raises that alarm's flag. Setting bit 7 of a field makes that field a wildcard.

The two flags can be read in a status register. A flag is cleared when software reads any register of its alarm. Each flag drives an active-low interrupt output only while its enable bit is set. A routing bit chooses between two arrangements:
- both alarms share the first interrupt pin, or
- alarm 1 drives its own second pin.

The first pin is open drain. It is modelled as an active-low level together with an output-enable that is high while the pin pulls low.

The serial register access and the time counting sit outside this unit. The neighbouring decoder presents a single-cycle read or write strobe with a register address. The time counter presents the current time bytes and a one-cycle tick after each update.

Top module: `alm_unit`

## Requirements
- R1: After reset, all eight alarm bytes, the control register and both flags are zero, both interrupt outputs are high, and the output-enable is low.
- R2: Alarm 0 occupies addresses 0x07..0x0A and alarm 1 occupies 0x0B..0x0E, with fields in the order seconds, minutes, hours, day of week. Each field is a fully writable byte that reads back as written.
- R3: The control register at 0x0F has three writable bits: bit 0 enables alarm 0, bit 1 enables alarm 1, and bit 2 is the routing bit. Bits 7..3 read zero.
- R4: The status register at 0x10 reads alarm 0's flag in bit 0 and alarm 1's flag in bit 1, with all other bits zero. Writes to it have no effect.
- R5: On a cycle with tick_i high, an alarm's flag becomes 1 in the next cycle if every field matches. A field matches when its bit 7 is set, or when its bits 6..0 equal bits 6..0 of the corresponding time input.
- R6: A time that matches an alarm does not set its flag on cycles where tick_i is low.
- R7: A flag is set on a match whether or not its enable bit is set. With the enable clear, the flag does not affect the interrupt outputs.
- R8: A read of any of an alarm's four addresses clears that alarm's flag from the next cycle on, and leaves the other alarm's flag unchanged. If a tick match for the same alarm falls in the same cycle as the read, the flag stays set.
- R9: With the routing bit clear, int0_no is low exactly when (flag0 and enable0) or (flag1 and enable1), and int1_no stays high.
- R10: With the routing bit set, int0_no is low exactly when flag0 and enable0 are both set, and int1_no is low exactly when flag1 and enable1 are both set.
- R11: int0_oe_o is high exactly when int0_no is low.
- R12: Reads of addresses outside 0x07..0x10 return zero, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Single-cycle register write strobe |
| rd_en_i | input | 1 | Single-cycle register read strobe |
| addr_i | input | 5 | Register address |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for addr_i (combinational) |
| tick_i | input | 1 | One-cycle pulse per second, after the time update |
| sec_i | input | 8 | Current seconds byte |
| min_i | input | 8 | Current minutes byte |
| hour_i | input | 8 | Current hours byte |
| wday_i | input | 8 | Current day-of-week byte |
| int0_no | output | 1 | First interrupt, active low |
| int0_oe_o | output | 1 | Drive enable for the open-drain first pin |
| int1_no | output | 1 | Second interrupt, active low |

## Verification
The hardest case to reach is a read that clears a flag landing in the same cycle as a tick that sets it again. The stimulus gives alarm 1 wildcard fields in every position, so that any tick is a match. It then issues a read of an alarm 1 address together with the tick strobe. A second corner is a flag raised while its enable is clear. The bench checks that the flag is visible in status but the pins stay high. It then sets the enable and checks that the pins fall without any further tick.

// File: rtl/alm_unit_pkg.sv
package alm_unit_pkg;
  localparam int AW = 5;
  localparam int DW = 8;
  localparam int NUM_FIELDS = 4;
  localparam int NUM_ALM = 2;
  localparam int CTRL_W = 3;
  localparam logic [AW-1:0] ALM_BASE  = 5'h07;
  localparam logic [AW-1:0] CTRL_ADDR = 5'h0F;
  localparam logic [AW-1:0] STAT_ADDR = 5'h10;
  // control bit positions
  localparam int CB_EN0   = 0;
  localparam int CB_EN1   = 1;
  localparam int CB_ROUTE = 2;
endpackage

// File: rtl/alm_field_match.sv
module alm_field_match #(
  parameter int DW = 8
) (
  input  logic [DW-1:0] alarm_i,
  input  logic [DW-1:0] now_i,
  output logic          hit_o
);
  // top bit is the wildcard
  assign hit_o = alarm_i[DW-1] | (alarm_i[DW-2:0] == now_i[DW-2:0]);
endmodule

// File: rtl/alm_channel.sv
module alm_channel #(
  parameter int DW = 8,
  parameter int NF = 4,
  localparam int FW = (NF > 1) ? $clog2(NF) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_i,
  input  logic [FW-1:0]    field_i,
  input  logic [DW-1:0]    wdata_i,
  input  logic             rd_clr_i,
  input  logic             tick_i,
  input  logic [NF*DW-1:0] now_i,
  output logic [NF*DW-1:0] fields_o,
  output logic             flag_o
);
  logic [NF-1:0] hit;
  logic          match;

  for (genvar f = 0; f < NF; f++) begin : g_field
    logic [DW-1:0] val_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                               val_q <= '0;
      else if (wr_i && (field_i == FW'(f)))      val_q <= wdata_i;
    end
    assign fields_o[f*DW +: DW] = val_q;
    alm_field_match #(.DW(DW)) u_match (
      .alarm_i (val_q),
      .now_i   (now_i[f*DW +: DW]),
      .hit_o   (hit[f])
    );
  end

  assign match = &hit;

  // set beats clear so a same-cycle match is not lost
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               flag_o <= 1'b0;
    else if (tick_i && match)  flag_o <= 1'b1;
    else if (rd_clr_i)         flag_o <= 1'b0;
  end

  // R5
  flag_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && match) |=> flag_o);
  // R6
  no_tick_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick_i && !rd_clr_i) |=> $stable(flag_o));
  // R8
  rd_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_clr_i && !(tick_i && match)) |=> !flag_o);
endmodule

// File: rtl/alm_irq_route.sv
module alm_irq_route (
  input  logic [1:0] flag_i,
  input  logic [1:0] en_i,
  input  logic       route_i,
  output logic       int0_no,
  output logic       int0_oe_o,
  output logic       int1_no
);
  logic [1:0] live;
  logic       pin0_act, pin1_act;

  assign live     = flag_i & en_i;
  assign pin0_act = route_i ? live[0] : |live;
  assign pin1_act = route_i & live[1];
  assign int0_no   = ~pin0_act;
  assign int0_oe_o = pin0_act;
  assign int1_no   = ~pin1_act;

  // R9
  always_comb if (!route_i) shared_pin1_idle_chk: assert (int1_no);
  // R7
  always_comb if (en_i == 2'b00) gated_idle_chk: assert (int0_no && int1_no);
  // R11
  always_comb oe_follow_chk: assert (int0_oe_o == !int0_no);
endmodule

// File: rtl/alm_unit.sv
module alm_unit
  import alm_unit_pkg::*;
#(
  parameter int ADDR_W = AW,
  parameter int DATA_W = DW
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic              tick_i,
  input  logic [DATA_W-1:0] sec_i,
  input  logic [DATA_W-1:0] min_i,
  input  logic [DATA_W-1:0] hour_i,
  input  logic [DATA_W-1:0] wday_i,
  output logic              int0_no,
  output logic              int0_oe_o,
  output logic              int1_no
);
  localparam int NF = NUM_FIELDS;
  localparam int FW = (NF > 1) ? $clog2(NF) : 1;

  logic [NF*DATA_W-1:0] now;
  logic [NF*DATA_W-1:0] fields [NUM_ALM];
  logic [NUM_ALM-1:0]   sel, flag;
  logic [FW-1:0]        fsel [NUM_ALM];
  logic [CTRL_W-1:0]    ctrl_q;

  assign now = {wday_i, hour_i, min_i, sec_i};

  for (genvar a = 0; a < NUM_ALM; a++) begin : g_alm
    localparam logic [ADDR_W-1:0] BASE = ADDR_W'(ALM_BASE) + ADDR_W'(a * NF);
    logic [ADDR_W-1:0] off;
    assign off     = addr_i - BASE;
    assign sel[a]  = (addr_i >= BASE) && (addr_i < BASE + ADDR_W'(NF));
    assign fsel[a] = off[FW-1:0];
    alm_channel #(.DW(DATA_W), .NF(NF)) u_chan (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .wr_i     (wr_en_i && sel[a]),
      .field_i  (fsel[a]),
      .wdata_i  (wdata_i),
      .rd_clr_i (rd_en_i && sel[a]),
      .tick_i   (tick_i),
      .now_i    (now),
      .fields_o (fields[a]),
      .flag_o   (flag[a])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                   ctrl_q <= '0;
    else if (wr_en_i && addr_i == ADDR_W'(CTRL_ADDR)) ctrl_q <= wdata_i[CTRL_W-1:0];
  end

  always_comb begin
    rdata_o = '0;
    for (int a = 0; a < NUM_ALM; a++)
      if (sel[a]) rdata_o = fields[a][fsel[a]*DATA_W +: DATA_W];
    if (addr_i == ADDR_W'(CTRL_ADDR)) rdata_o = DATA_W'(ctrl_q);
    if (addr_i == ADDR_W'(STAT_ADDR)) rdata_o = DATA_W'(flag);
  end

  alm_irq_route u_route (
    .flag_i    (flag),
    .en_i      ({ctrl_q[CB_EN1], ctrl_q[CB_EN0]}),
    .route_i   (ctrl_q[CB_ROUTE]),
    .int0_no   (int0_no),
    .int0_oe_o (int0_oe_o),
    .int1_no   (int1_no)
  );

  // R4
  stat_write_ignored_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == ADDR_W'(STAT_ADDR) && !tick_i && !rd_en_i) |=> $stable(flag));
  // R3
  ctrl_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_en_i && addr_i == ADDR_W'(CTRL_ADDR)) |=> $stable(ctrl_q));
endmodule

// File: tb/alm_unit_test.sv
module alm_unit_test;
  logic       clk = 1'b0, rst_ni = 1'b0;
  logic       wr_en = 1'b0, rd_en = 1'b0, tick = 1'b0;
  logic [4:0] addr = '0;
  logic [7:0] wdata = '0, sec = '0, mnt = '0, hr = '0, wd = '0;
  logic [7:0] rdata;
  logic       int0_n, int0_oe, int1_n;
  int n_vec = 0, n_bad = 0;

  always #2 clk = ~clk;

  alm_unit uut (
    .clk_i(clk), .rst_ni(rst_ni), .wr_en_i(wr_en), .rd_en_i(rd_en),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .tick_i(tick),
    .sec_i(sec), .min_i(mnt), .hour_i(hr), .wday_i(wd),
    .int0_no(int0_n), .int0_oe_o(int0_oe), .int1_no(int1_n)
  );

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic idle();
    @(posedge clk); #1;
    wr_en = 0; rd_en = 0; tick = 0;
  endtask

  task automatic wr(logic [4:0] a, logic [7:0] d);
    @(negedge clk); wr_en = 1; addr = a; wdata = d; idle();
  endtask

  task automatic rd(logic [4:0] a, logic [7:0] exp, string tag);
    @(negedge clk); rd_en = 1; addr = a; #1; chk(tag, rdata, exp); idle();
  endtask

  task automatic set_time(logic [7:0] s, m, h, w, logic t);
    @(negedge clk); sec = s; mnt = m; hr = h; wd = w; tick = t; idle();
  endtask

  task automatic pins(logic i0, logic i1, string tag);
    @(negedge clk); #1;
    chk({tag, " int0"}, {7'd0, int0_n}, {7'd0, i0});
    chk({tag, " int1"}, {7'd0, int1_n}, {7'd0, i1});
    chk("R11 oe", {7'd0, int0_oe}, {7'd0, ~i0});
  endtask

  task automatic t_reset();
    for (int a = 7; a <= 16; a++) rd(5'(a), 8'h00, "R1 reg");
    pins(1, 1, "R1");
  endtask

  task automatic t_regmap();
    for (int a = 7; a <= 14; a++) wr(5'(a), 8'(8'h11 * (a - 6)));
    for (int a = 7; a <= 14; a++) rd(5'(a), 8'(8'h11 * (a - 6)), "R2 readback");
    wr(5'h0F, 8'hFF); rd(5'h0F, 8'h07, "R3 ctrl");
    wr(5'h0F, 8'h00);
    wr(5'h10, 8'hFF); rd(5'h10, 8'h00, "R4 status write");
    wr(5'h1F, 8'hAA); wr(5'h03, 8'h55);
    rd(5'h1F, 8'h00, "R12 unmapped read");
    rd(5'h0F, 8'h00, "R12 ctrl untouched");
    rd(5'h07, 8'h11, "R12 alarm untouched");
  endtask

  task automatic t_match();
    wr(5'h07, 8'h30); wr(5'h08, 8'h15); wr(5'h09, 8'h08); wr(5'h0A, 8'h03);
    wr(5'h0B, 8'h00); wr(5'h0C, 8'h00); wr(5'h0D, 8'h00); wr(5'h0E, 8'h00);
    rd(5'h07, 8'h30, "R2 clear alm0"); rd(5'h0B, 8'h00, "R2 clear alm1");
    set_time(8'h30, 8'h15, 8'h08, 8'h03, 0);
    rd(5'h10, 8'h00, "R6 no tick");
    set_time(8'h31, 8'h15, 8'h08, 8'h03, 1);
    rd(5'h10, 8'h00, "R5 seconds differ");
    set_time(8'h30, 8'h15, 8'h08, 8'h04, 1);
    rd(5'h10, 8'h00, "R5 weekday differ");
    set_time(8'h30, 8'h15, 8'h08, 8'h03, 1);
    rd(5'h10, 8'h01, "R5 full match");
    pins(1, 1, "R7 disabled");
    wr(5'h0F, 8'h01);
    pins(0, 1, "R9 enabled alm0");
    rd(5'h0C, 8'h00, "R8 other alarm read");
    rd(5'h10, 8'h01, "R8 flag0 kept");
    rd(5'h09, 8'h08, "R8 clear read");
    rd(5'h10, 8'h00, "R8 flag0 cleared");
    pins(1, 1, "R8 pins released");
  endtask

  task automatic t_mask();
    wr(5'h07, 8'h80); wr(5'h08, 8'h80); wr(5'h09, 8'h12); wr(5'h0A, 8'h80);
    set_time(8'h59, 8'h42, 8'h12, 8'h06, 1);
    rd(5'h10, 8'h01, "R5 wildcard fields");
    rd(5'h07, 8'h80, "R8 ack alm0");
    set_time(8'h59, 8'h42, 8'h13, 8'h06, 1);
    rd(5'h10, 8'h00, "R5 hour differs");
    for (int a = 11; a <= 14; a++) wr(5'(a), 8'h80);
    wr(5'h0F, 8'h02);
    set_time(8'h01, 8'h02, 8'h03, 8'h04, 1);
    rd(5'h10, 8'h02, "R5 alm1 all wildcard");
    pins(0, 1, "R9 shared pin");
    wr(5'h0F, 8'h06);
    pins(1, 0, "R10 routed alm1");
    wr(5'h0F, 8'h07);
    set_time(8'h00, 8'h00, 8'h12, 8'h00, 1);
    rd(5'h10, 8'h03, "R10 both flags");
    pins(0, 0, "R10 both pins");
    wr(5'h0F, 8'h03);
    pins(0, 1, "R9 shared both");
  endtask

  task automatic t_race();
    @(negedge clk); rd_en = 1; addr = 5'h0D; tick = 1;
    sec = 8'h10; mnt = 8'h20; hr = 8'h05; wd = 8'h02; idle();
    rd(5'h10, 8'h03, "R8 set wins over read");
    rd(5'h0E, 8'h80, "R8 ack alm1");
    rd(5'h10, 8'h01, "R8 flag1 cleared");
  endtask

  initial begin
    #(100000 * 4);
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    #9 rst_ni = 1'b1;
    t_reset();
    t_regmap();
    t_match();
    t_mask();
    t_race();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule